// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial bus slave that gives a host controller read and write access to a small bank of byte-wide configuration registers. The register contents are presented continuously as one flat parallel vector, so a video datapath can take its mode and colour settings straight from the bank without any further handshake. SCL and SDA are oversampled in the system clock domain. The slave pulls SDA low through an open-drain enable and never drives it high.

A transaction opens with a START and an address byte. That byte carries a 7-bit device address, which is a parameter, and a direction bit. A write continues with a pointer byte that selects a register, then data bytes that land at the pointer and advance it by one each. A read first sets the pointer with a short write, then issues a repeated START with the direction bit set, and then clocks bytes out of the bank until the host declines one. Pointers outside the bank are refused, and so are writes that run past the last register. A read that runs past the last register keeps returning that register. A START or STOP that arrives in the middle of a byte abandons the transfer.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, all NUM_REGS registers read 00h on `regs_o` and `sda_oe` is 0 (SDA released).
- R2: The first byte after a START is taken MSB first. Bits [7:1] are the device address and bit 0 is the direction (0 = host writes, 1 = host reads). On a match the slave pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores every byte until the next START.
- R3: In a write, the byte after the address is the register pointer. A value below NUM_REGS (00h to 08h by default, so bit 7 is 0) is acknowledged and loaded. Any other value is not acknowledged, the slave goes idle, and any bytes that follow get no acknowledge and change no register.
- R4: Each data byte of a write is acknowledged and stored in the register the pointer names, and then the pointer advances by one. Register k appears on `regs_o[8k+7:8k]`.
- R5: A write data byte that arrives when the pointer has passed the last register is not stored and not acknowledged, and the slave goes idle.
- R6: After a repeated START with the direction bit at 1, the slave sends the register at the pointer, MSB first. After each byte the host acknowledges, the pointer advances.
- R7: Once a read has reached the last register, further acknowledged reads return the last register again. When the host does not acknowledge, the slave releases SDA and goes idle.
- R8: A STOP or START in the middle of a byte abandons it and nothing is stored. A START begins a new address byte, and SDA is released in the clock after a STOP is seen.
- R9: The slave changes `sda_oe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | NUM_REGS*8 | Register bank, register k at bits [8k+7:8k] |

## Verification
A pin change passes two synchronizer flops and one edge flop, so the controller acts on it in the third clock. `sda_oe` follows one clock after that, and a stored byte reaches `regs_o` one clock after the controller decides to accept it. The bench holds every bus phase for ten clocks. It samples acknowledges and read bits in the middle of the SCL high phase, by which time every one of these results has settled. The reference register image is updated when SCL rises for the acknowledge bit, and it is compared against `regs_o` only while the modelled SCL is high, so a write that lands during the low phase is never compared early.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_SACK,
    ST_TX,
    ST_MACK
  } phase_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_SUB,
    RX_DATA
  } role_t;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'b00;
    else        q <= {q[0], 1'b1};
  end

  assign rst_n_s = q[1];
endmodule

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int NEW = STAGES - 2;
  localparam int OLD = STAGES - 1;

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
    end
  end

  assign scl_s     = scl_q[NEW];
  assign sda_s     = sda_q[NEW];
  assign scl_rise  = scl_q[NEW] & ~scl_q[OLD];
  assign scl_fall  = ~scl_q[NEW] & scl_q[OLD];
  assign start_evt = scl_q[NEW] & scl_q[OLD] & sda_q[OLD] & ~sda_q[NEW];
  assign stop_evt  = scl_q[NEW] & scl_q[OLD] & ~sda_q[OLD] & sda_q[NEW];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int PW       = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PW-1:0]              wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [PW-1:0]              rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic q;
    logic [BYTE_W-1:0] val_q;
    assign q = wr_en && (wr_idx == PW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (q)  val_q <= wr_data;
    end

    assign regs_o[k*BYTE_W +: BYTE_W] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_idx == PW'(k)) rd_data = regs_o[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         NUM_REGS = 9,
  parameter int         PW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PW-1:0]     rd_idx,
  output logic              wr_en,
  output logic [PW-1:0]     wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [PW-1:0]     TOP_IDX = PW'(NUM_REGS - 1);
  localparam logic [PW-1:0]     END_IDX = PW'(NUM_REGS);
  localparam logic [BYTE_W-1:0] SUB_LIM = BYTE_W'(NUM_REGS);
  localparam logic [3:0]        LAST_BIT = 4'd8;

  phase_t            phase_q, phase_d, after_q, after_d;
  role_t             role_q, role_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [PW-1:0]     ptr_q, ptr_d;
  logic              oe_q, oe_d;

  assign rd_idx  = (ptr_q > TOP_IDX) ? TOP_IDX : ptr_q;
  assign wr_idx  = ptr_q;
  assign wr_data = shreg_q;
  assign sda_oe  = oe_q;

  always_comb begin
    phase_d  = phase_q;
    after_d  = after_q;
    role_d   = role_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    ptr_d    = ptr_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;
    if (start_evt) begin
      phase_d  = ST_RX;
      role_d   = RX_DEV;
      bitcnt_d = '0;
      oe_d     = 1'b0;
    end else if (stop_evt) begin
      phase_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (phase_q)
        ST_RX: begin
          if (scl_rise && bitcnt_q != LAST_BIT) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == LAST_BIT) begin
            bitcnt_d = '0;
            phase_d  = ST_SACK;
            after_d  = ST_RX;
            oe_d     = 1'b1;
            case (role_q)
              RX_DEV: begin
                if (shreg_q[7:1] != DEV_ADDR) begin
                  phase_d = ST_IDLE;
                  oe_d    = 1'b0;
                end else if (shreg_q[0]) begin
                  after_d = ST_TX;
                end else begin
                  role_d = RX_SUB;
                end
              end
              RX_SUB: begin
                if (shreg_q < SUB_LIM) begin
                  ptr_d  = shreg_q[PW-1:0];
                  role_d = RX_DATA;
                end else begin
                  phase_d = ST_IDLE;
                  oe_d    = 1'b0;
                end
              end
              default: begin
                if (ptr_q < END_IDX) begin
                  wr_en = 1'b1;
                  ptr_d = ptr_q + PW'(1);
                end else begin
                  phase_d = ST_IDLE;
                  oe_d    = 1'b0;
                end
              end
            endcase
          end
        end
        ST_SACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            phase_d  = after_q;
            if (after_q == ST_TX) begin
              shreg_d = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
            end else begin
              oe_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == LAST_BIT) begin
              phase_d = ST_MACK;
              oe_d    = 1'b0;
            end else begin
              shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
              oe_d    = ~shreg_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_s) begin
              phase_d = ST_IDLE;
            end else begin
              phase_d = ST_SACK;
              after_d = ST_TX;
              if (ptr_q < TOP_IDX) ptr_d = ptr_q + PW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= ST_IDLE;
      after_q  <= ST_RX;
      role_q   <= RX_DEV;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      oe_q     <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      after_q  <= after_d;
      role_q   <= role_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      oe_q     <= oe_d;
    end
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         NUM_REGS = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  localparam int PW = $clog2(NUM_REGS + 1);

  logic              rst_n_s;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_en;
  logic [PW-1:0]     wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  i2c_bus_sync #(.STAGES(3)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PW(PW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .PW(PW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
  parameter int NUM_REGS = 9,
  parameter int PW       = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  stop_evt,
  input logic                  wr_en,
  input logic [PW-1:0]         wr_idx,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] regs
);
  localparam logic [PW-1:0] END_IDX = PW'(NUM_REGS);

  // R9
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);

  // R4
  write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R5
  write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < END_IDX));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R4
  regs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NUM_REGS(NUM_REGS), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .scl_s    (scl_s),
  .stop_evt (stop_evt),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .sda_oe   (sda_oe),
  .regs     (regs_o)
);

// File: tb/test_i2c_cfg_slave.sv
`timescale 1ns/1ps
module test_i2c_cfg_slave;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int NREG = 9;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_reg [NREG];

  always #4 clk = ~clk;

  i2c_cfg_slave #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) i_i2c_cfg_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .regs_o (regs_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [NREG*8-1:0] image();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*8 +: 8] = exp_reg[k];
    return v;
  endfunction

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; q();
      scl_m = 1'b1; q(); q();
      scl_m = 1'b0; q();
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input int upd, input string tag);
    logic got;
    send_bits(b, 8);
    sda_m = 1'b1; q();
    scl_m = 1'b1;
    if (upd >= 0) exp_reg[upd] = b;
    q();
    got = ~sda_line;
    chk(got == exp_ack, {tag, " ack bit"}, got, exp_ack);
    q();
    scl_m = 1'b0; q();
  endtask

  task automatic rd_byte(input bit nack, input logic [7:0] expb, input string tag);
    logic [7:0] got;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q();
      scl_m = 1'b1; q();
      got[i] = sda_line; q();
      scl_m = 1'b0;
    end
    chk(got == expb, {tag, " read byte"}, got, expb);
    q();
    sda_m = nack; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  // Continuous model comparison: register image (R4, R5) and SDA hold rule (R9)
  initial begin
    logic prev_scl;
    logic prev_oe;
    prev_scl = 1'b1;
    prev_oe = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
        if (scl_m) chk(regs_o == image(), "R4 R5 register image", regs_o, image());
        if (scl_m && prev_scl) chk(sda_oe == prev_oe, "R9 sda_oe moved with SCL high", sda_oe, prev_oe);
      end
      prev_scl = scl_m;
      prev_oe = sda_oe;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) exp_reg[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(regs_o == '0, "R1 registers clear", regs_o, 0);

    // R2 R3 R4: burst write from pointer 0
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R2 address match");
    wr_byte(8'h00, 1, -1, "R3 pointer 00h");
    wr_byte(8'hA5, 1, 0, "R4 data reg0");
    wr_byte(8'h3C, 1, 1, "R4 data reg1");
    wr_byte(8'h7E, 1, 2, "R4 data reg2");
    bus_stop();
    chk(regs_o[15:8] == 8'h3C, "R4 reg1 field", regs_o[15:8], 8'h3C);

    // R2: wrong device address is ignored
    bus_start();
    wr_byte({ADDR ^ 7'h01, 1'b0}, 0, -1, "R2 address mismatch");
    wr_byte(8'h00, 0, -1, "R2 ignored pointer");
    wr_byte(8'hFF, 0, -1, "R2 ignored data");
    bus_stop();
    chk(regs_o[7:0] == 8'hA5, "R2 reg0 untouched", regs_o[7:0], 8'hA5);

    // R3: invalid pointers
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R3 address");
    wr_byte(8'h09, 0, -1, "R3 pointer 09h");
    wr_byte(8'h11, 0, -1, "R3 data after refusal");
    bus_stop();
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R3 address");
    wr_byte(8'h81, 0, -1, "R3 pointer with bit7");
    wr_byte(8'h22, 0, -1, "R3 data after refusal");
    bus_stop();
    chk(regs_o[15:8] == 8'h3C, "R3 reg1 untouched", regs_o[15:8], 8'h3C);

    // R5: write past the top of the bank
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R5 address");
    wr_byte(8'h07, 1, -1, "R5 pointer 07h");
    wr_byte(8'h77, 1, 7, "R5 data reg7");
    wr_byte(8'h88, 1, 8, "R5 data reg8");
    wr_byte(8'h99, 0, -1, "R5 overflow byte");
    wr_byte(8'hAA, 0, -1, "R5 after overflow");
    bus_stop();
    chk(regs_o[71:64] == 8'h88, "R5 reg8 kept", regs_o[71:64], 8'h88);

    // R6: pointer set then repeated START read
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R6 address write");
    wr_byte(8'h00, 1, -1, "R6 pointer");
    bus_start();
    wr_byte({ADDR, 1'b1}, 1, -1, "R6 address read");
    rd_byte(1'b0, 8'hA5, "R6 reg0");
    rd_byte(1'b0, 8'h3C, "R6 reg1");
    rd_byte(1'b1, 8'h7E, "R6 reg2");
    bus_stop();

    // R7: read past the top repeats the last register
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R7 address write");
    wr_byte(8'h07, 1, -1, "R7 pointer");
    bus_start();
    wr_byte({ADDR, 1'b1}, 1, -1, "R7 address read");
    rd_byte(1'b0, 8'h77, "R7 reg7");
    rd_byte(1'b0, 8'h88, "R7 reg8");
    rd_byte(1'b0, 8'h88, "R7 reg8 repeat");
    rd_byte(1'b1, 8'h88, "R7 reg8 last");
    chk(sda_oe == 1'b0, "R7 released after host nack", sda_oe, 0);
    bus_stop();

    // R8: STOP in the middle of a data byte
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R8 address");
    wr_byte(8'h03, 1, -1, "R8 pointer");
    send_bits(8'hF0, 4);
    bus_stop();
    chk(regs_o[31:24] == 8'h00, "R8 partial byte dropped", regs_o[31:24], 0);
    chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);

    // R8: START in the middle of an address byte, then a fresh write
    bus_start();
    send_bits(8'hC0, 3);
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R8 address after restart");
    wr_byte(8'h04, 1, -1, "R8 pointer");
    send_bits(8'h0F, 5);
    bus_start();
    wr_byte({ADDR, 1'b0}, 1, -1, "R8 address after data abort");
    wr_byte(8'h04, 1, -1, "R8 pointer again");
    wr_byte(8'h5A, 1, 4, "R8 data reg4");
    bus_stop();
    chk(regs_o[39:32] == 8'h5A, "R8 reg4 written", regs_o[39:32], 8'h5A);

    q();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule